// File: doc/BRIEF.md
# Single-Wire LED Bit Encoder

The encoder turns a stream of 24-bit pixel words into the pulse train that a chain of single-wire addressable LEDs reads. Every data bit fills a frame of ten time slots, each slot one period of an external clock-enable tick. The line goes high at the start of the frame and then drops low. A short high phase encodes a zero and a long high phase encodes a one. Whole-slot rounding is acceptable because the line tolerates roughly 150 ns of error on each pulse. At the intended tick rate of 8 MHz, one slot lasts 125 ns and one bit lasts 1.25 µs, which gives 800 kHz.

Words arrive on a valid/ready stream. The encoder can take the next word during the final slot of the current word. A producer that keeps words queued therefore gets a continuous pulse train. When the queue runs dry, the line stays low for a fixed latch interval. During that interval no word is taken, so the LEDs can latch the frame. A one-clock done pulse marks the end of each word.

Top module: `led_bit_encoder`

## Requirements
- R1: Each bit lasts exactly 10 tick slots. The line is high for the leading slots and low for the rest of the frame.
- R2: A bit of value 0 gives 3 high slots followed by 7 low slots.
- R3: A bit of value 1 gives 6 high slots followed by 4 low slots.
- R4: Bit 23 of a word is sent first and bit 0 last. One word is 24 bits, which is 240 slots.
- R5: `led_out` changes only on a clock edge where `tick` is 1. With `tick` at 0 it holds its value.
- R6: A word is taken on a rising clock edge where `px_valid` and `px_ready` are both 1. `px_ready` is 1 while the encoder is idle. During a word, `px_ready` is 1 only while `tick` is 1 in the final slot of the last bit. At all other times during a word it is 0.
- R7: A word taken on the final slot of the previous word starts its first high slot on the very next tick. No idle slot comes between the two words.
- R8: `word_done` is 1 for exactly one clock, right after the edge that ends the last slot of a word.
- R9: After a word that is not followed at once by another, `led_out` stays 0 and `px_ready` stays 0 for 400 ticks. `px_ready` returns to 1 after the 400th tick.
- R10: While `rst_n` is 0 at a rising edge, the encoder returns to idle synchronously. `led_out` and `word_done` go to 0, `px_ready` goes to 1, and a word in progress is dropped.
- R11: While idle, and after a word is taken but before its first tick, `led_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slot enable: one pulse per 125 ns slot |
| px_valid | input | 1 | Pixel word offered |
| px_ready | output | 1 | Encoder can take a pixel word this edge |
| px_data | input | 24 | Pixel word, bit 23 sent first |
| led_out | output | 1 | Serial LED data line |
| word_done | output | 1 | One-clock pulse at the end of each word |

## Verification
The bench goes after the word boundary. A hand-off that came one slot late would put a low slot at the start of the next word. An encoder that missed the final-slot ready window would fall into the latch gap between two queued words. The bench also counts the latch gap to its exact last tick, so a counter off by one either releases `px_ready` early or holds it for an extra tick. It checks the line between ticks, which catches any logic that updates the pin on every clock. It also resets in the middle of a word, so a bit or slot counter that is not cleared would distort the first bit of the following word.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } enc_state_t;

endpackage

// File: rtl/led_slot_timer.sv
// Counts slots inside one bit frame and says whether the current slot is high.
module led_slot_timer #(
   parameter int SLOTS_PER_BIT = 10,
   parameter int HIGH_ZERO     = 3,
   parameter int HIGH_ONE      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   input  logic bit_val,
   output logic slot_high,
   output logic last_slot
);
   localparam int SW = (SLOTS_PER_BIT > 1) ? $clog2(SLOTS_PER_BIT) : 1;
   localparam logic [SW-1:0] LAST_C = SW'(SLOTS_PER_BIT - 1);
   localparam logic [SW-1:0] H0_C   = SW'(HIGH_ZERO);
   localparam logic [SW-1:0] H1_C   = SW'(HIGH_ONE);

   logic [SW-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         slot_q <= '0;
      end else if (adv) begin
         slot_q <= (slot_q == LAST_C) ? '0 : slot_q + 1'b1;
      end
   end

   always_comb begin
      last_slot = (slot_q == LAST_C);
      slot_high = bit_val ? (slot_q < H1_C) : (slot_q < H0_C);
   end

   // R1: a frame always wraps back to slot zero after its final slot
   a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last_slot && !clr) |=> (slot_q == '0));

endmodule

// File: rtl/led_word_shifter.sv
// Holds the word being sent and counts its bits.
module led_word_shifter #(
   parameter int WORD_W    = 24,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   output logic              cur_bit,
   output logic              last_bit
);
   localparam int BW = $clog2(WORD_W);
   localparam logic [BW-1:0] LASTB_C = BW'(WORD_W - 1);

   logic [WORD_W-1:0] sreg_q;
   logic [BW-1:0]     bcnt_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)      sreg_q <= '0;
            else if (load)   sreg_q <= load_word;
            else if (shift)  sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
         end
         assign cur_bit = sreg_q[WORD_W-1];
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)      sreg_q <= '0;
            else if (load)   sreg_q <= load_word;
            else if (shift)  sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
         end
         assign cur_bit = sreg_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         bcnt_q <= '0;
      end else if (shift) begin
         bcnt_q <= (bcnt_q == LASTB_C) ? '0 : bcnt_q + 1'b1;
      end
   end

   assign last_bit = (bcnt_q == LASTB_C);

   // R4: the bit count restarts after the final bit of a word
   a_r4_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && last_bit && !load) |=> (bcnt_q == '0));

endmodule

// File: rtl/led_gap_timer.sv
// Counts ticks of the latch interval that follows the last queued word.
module led_gap_timer #(
   parameter int GAP_TICKS = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic adv,
   output logic expire
);
   localparam int GW = $clog2(GAP_TICKS);
   localparam logic [GW-1:0] LASTG_C = GW'(GAP_TICKS - 1);

   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || start) begin
         cnt_q <= '0;
      end else if (adv && cnt_q != LASTG_C) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = adv && (cnt_q == LASTG_C);

endmodule

// File: rtl/led_bit_encoder.sv
module led_bit_encoder
   import led_enc_pkg::*;
#(
   parameter int WORD_W        = 24,
   parameter int SLOTS_PER_BIT = 10,
   parameter int HIGH_ZERO     = 3,
   parameter int HIGH_ONE      = 6,
   parameter int GAP_TICKS     = 400,
   parameter bit MSB_FIRST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              px_valid,
   output logic              px_ready,
   input  logic [WORD_W-1:0] px_data,
   output logic              led_out,
   output logic              word_done
);
   generate
      if (HIGH_ZERO < 1 || HIGH_ZERO >= HIGH_ONE || HIGH_ONE >= SLOTS_PER_BIT) begin : g_bad_pulse
         $error("pulse widths must satisfy 0 < HIGH_ZERO < HIGH_ONE < SLOTS_PER_BIT");
      end
      if (WORD_W < 2 || GAP_TICKS < 2) begin : g_bad_size
         $error("WORD_W and GAP_TICKS must be at least 2");
      end
   endgenerate

   enc_state_t state_q, state_d;
   logic send_adv, gap_adv, bit_end, word_end, accept;
   logic slot_high, last_slot, cur_bit, last_bit, gap_expire;

   assign send_adv = tick && (state_q == ST_SEND);
   assign gap_adv  = tick && (state_q == ST_GAP);
   assign bit_end  = send_adv && last_slot;
   assign word_end = bit_end && last_bit;
   assign px_ready = (state_q == ST_IDLE) || word_end;
   assign accept   = px_valid && px_ready;

   led_slot_timer #(
      .SLOTS_PER_BIT (SLOTS_PER_BIT),
      .HIGH_ZERO     (HIGH_ZERO),
      .HIGH_ONE      (HIGH_ONE)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .adv       (send_adv),
      .bit_val   (cur_bit),
      .slot_high (slot_high),
      .last_slot (last_slot)
   );

   led_word_shifter #(
      .WORD_W    (WORD_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (px_data),
      .shift     (bit_end),
      .cur_bit   (cur_bit),
      .last_bit  (last_bit)
   );

   led_gap_timer #(
      .GAP_TICKS (GAP_TICKS)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (word_end && !accept),
      .adv    (gap_adv),
      .expire (gap_expire)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept)     state_d = ST_SEND;
         ST_SEND: if (word_end)   state_d = accept ? ST_SEND : ST_GAP;
         ST_GAP:  if (gap_expire) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         led_out   <= 1'b0;
         word_done <= 1'b0;
      end else begin
         state_q   <= state_d;
         word_done <= word_end;
         if (send_adv) led_out <= slot_high;
      end
   end

   // R5: the line holds its level on edges without a tick
   a_r5_pin_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(led_out));

   // R8: the done pulse never spans two clocks
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> !word_done);

   // R9: the latch interval keeps the line low and refuses words
   a_r9_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP) |-> (!led_out && !px_ready));

   // R11: nothing drives the line high while idle
   a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !led_out);

endmodule

// File: tb/led_bit_encoder_bench.sv
`timescale 1ns/1ps
module led_bit_encoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        px_valid = 1'b0;
   logic [23:0] px_data = '0;
   logic        px_ready, led_out, word_done;
   int          total = 0;
   int          bad = 0;

   localparam logic [23:0] VEC [0:5] = '{
      24'h000000, 24'hFFFFFF, 24'h800001, 24'hA5A5A5, 24'h5A0F3C, 24'h123456
   };

   always #2 clk = ~clk;

   led_bit_encoder u_led_bit_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .px_valid  (px_valid),
      .px_ready  (px_ready),
      .px_data   (px_data),
      .led_out   (led_out),
      .word_done (word_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic load_idle(input logic [23:0] w);
      @(negedge clk);
      px_valid = 1'b1; px_data = w; tick = 1'b0;
      #1 chk("R6 ready while idle", px_ready, 1);
      @(posedge clk); #1;
      chk("R11 line low before first tick", led_out, 0);
      @(negedge clk);
      px_valid = 1'b0;
   endtask

   task automatic play(input logic [23:0] w, input bit b2b_in, input bit has_next,
                       input logic [23:0] nxt);
      for (int b = 0; b < 24; b++) begin
         for (int c = 0; c < 10; c++) begin
            bit last;
            int hi;
            last = (b == 23 && c == 9);
            hi = w[23-b] ? 6 : 3;
            @(negedge clk);
            tick = 1'b1;
            if (last && has_next) begin px_valid = 1'b1; px_data = nxt; end
            #1;
            if (last) chk("R6 ready on final slot", px_ready, 1);
            else if (c == 4) chk("R6 ready low mid-word", px_ready, 0);
            @(posedge clk); #1;
            if (w[23-b]) chk("R3 one-bit pulse, R1 R4 framing", led_out, c < hi);
            else         chk("R2 zero-bit pulse, R1 R4 framing", led_out, c < hi);
            if (b2b_in && b == 0 && c == 0) chk("R7 no gap before next word", led_out, 1);
            chk("R8 done at word end", word_done, last);
            @(negedge clk);
            tick = 1'b0; px_valid = 1'b0;
            @(posedge clk); #1;
            chk("R5 pin holds between ticks", led_out, c < hi);
            chk("R8 done lasts one clock", word_done, 0);
         end
      end
   endtask

   task automatic gap_check();
      for (int k = 1; k <= 400; k++) begin
         @(negedge clk);
         tick = 1'b1;
         if (k == 200) begin px_valid = 1'b1; px_data = 24'hFFFFFF; end
         #1 chk("R9 ready low in gap", px_ready, 0);
         @(posedge clk); #1;
         chk("R9 line low in gap", led_out, 0);
         @(negedge clk);
         tick = 1'b0; px_valid = 1'b0;
      end
      #1 chk("R9 ready back after 400 ticks", px_ready, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 led low after reset", led_out, 0);
      chk("R10 ready high after reset", px_ready, 1);
      chk("R10 done low after reset", word_done, 0);

      // vector table walked back-to-back
      load_idle(VEC[0]);
      for (int i = 0; i < 6; i++) begin
         play(VEC[i], i != 0, i != 5, (i != 5) ? VEC[(i + 1) % 6] : 24'h0);
      end
      gap_check();

      // no ticks: line stays low, ready low during the word
      load_idle(24'hFFFFFF);
      for (int k = 0; k < 5; k++) begin
         @(posedge clk); #1;
         chk("R5 no tick keeps line low", led_out, 0);
         chk("R6 ready low while word pending", px_ready, 0);
      end

      // reset in the middle of a word
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); tick = 1'b1;
         @(posedge clk); #1;
         chk("R3 first slots of one-bit high", led_out, 1);
         @(negedge clk); tick = 1'b0;
      end
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R10 led dropped by reset", led_out, 0);
      chk("R10 ready after mid-word reset", px_ready, 1);
      chk("R10 done low after mid-word reset", word_done, 0);
      @(negedge clk); rst_n = 1'b1;

      // counters restarted: full word after reset
      load_idle(24'h800001);
      play(24'h800001, 1'b0, 1'b0, 24'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule